// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a segment reference into a physical word address. A reference carries a 4-bit kind tag, a 23-bit index into a segment table held in memory, and a word offset into the segment. Before any memory access, the translator sorts the tag into one of three classes: a live descriptor, a descriptor that was never allocated, or an illegal tag. For a live descriptor it needs the table entry for that index. It first looks in a small fully associative cache. On a miss it reads the first two words of the eight-word entry through a memory read port and puts the result in the cache. It then checks that the segment is present, checks the offset against the segment length, and returns either the base plus the offset or a fault code.

The management software keeps every copy of a descriptor valid by changing only the table entry, because the index in a descriptor never changes. After it relocates, resizes or swaps out a segment, it sends an invalidate for that index so that the next reference reads the table again. The translator serves one lookup at a time. A hit returns in the second cycle after the request is accepted.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` and `mem_req` are 0. The cache holds no entries, so the first lookup of any index reads memory.
- R2: Tag 5 gives status 1 (unallocated). Any tag other than 5 and 0xC..0xF gives status 4 (illegal tag). Neither case reads memory. For tags 0xC..0xF, `resp_kind` returns tag bits [1:0]: bit 1 means indexed and bit 0 means paged.
- R3: A miss reads word address TABLE_BASE + index*8 and then TABLE_BASE + index*8 + 1. Each read is a request held for one cycle. In word 0, bit 47 is the present flag and bits [35:0] are the base. In word 1, bits [19:0] are the length.
- R4: For a present segment with offset < length, status is 0 and `resp_addr` = base + offset.
- R5: An absent segment gives status 2. This takes priority over the bounds check.
- R6: offset >= length on a present segment gives status 3. On any status other than 0, `resp_addr` is 0.
- R7: A repeated lookup of a cached index makes no memory read. `resp_valid` rises in the second cycle after the request is accepted.
- R8: The cache holds 8 entries and replaces them in round-robin order. After 9 distinct fills, the first index misses and the later ones still hit.
- R9: An invalidate for an index removes the cached entry from the next cycle on. The next lookup reads the table again and returns the new contents.
- R10: If an invalidate for the index being fetched arrives during the fetch, the fetched entry is not installed and the entry is read again, four reads in all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Translator idle, request accepted this cycle |
| req_tag | input | 4 | Descriptor kind tag |
| req_index | input | 23 | Segment table index |
| req_offset | input | 20 | Word offset into segment |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_status | output | 3 | 0 ok, 1 unallocated, 2 absent, 3 bounds, 4 illegal tag |
| resp_kind | output | 2 | Indexed/paged bits of a live tag |
| resp_addr | output | 36 | Physical word address, 0 on fault |
| mem_req | output | 1 | Table word read request |
| mem_addr | output | 36 | Table word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 48 | Read data word |
| inv_valid | input | 1 | Invalidate request |
| inv_index | input | 23 | Index to drop from the cache |

## Verification
Random lookups draw from a pool of twelve indices, more than the cache holds. This mixes hits, misses and evictions with every tag class, and offsets fall on both sides of the segment length. Comparing those results with a table model shows whether the fault priority and the address sum are right, whatever the cache holds. Directed cases count memory reads and response latency to tell a hit from a miss. They walk nine fills to expose the replacement order and place `offset = length - 1` against `offset = length` to find an off-by-one in the bound. They also change table contents behind an invalidate, both while idle and during a fetch, to show whether stale entries survive.

// File: rtl/seg_xlate_pkg.sv
// Shared constants for the segment translator: result codes and tag values.
// Assumes a 4-bit descriptor tag and a 3-bit status code.
package seg_xlate_pkg;
    localparam logic [2:0] ST_OK       = 3'd0;
    localparam logic [2:0] ST_UNALLOC  = 3'd1;
    localparam logic [2:0] ST_ABSENT   = 3'd2;
    localparam logic [2:0] ST_BOUNDS   = 3'd3;
    localparam logic [2:0] ST_BADTAG   = 3'd4;

    localparam logic [3:0] TAG_UNALLOC = 4'h5;
    localparam logic [1:0] TAG_LIVE_HI = 2'b11;
endpackage

// File: rtl/seg_tag_decode.sv
// Sorts a descriptor tag into unallocated, live or illegal.
// A live tag has its top two bits set. Its low two bits give the
// indexed/paged kind. Pure combinational logic.
module seg_tag_decode
    import seg_xlate_pkg::*;
(
    input  logic [3:0] tag,
    output logic       is_unalloc,
    output logic       is_live,
    output logic [1:0] kind
);
    // classify the tag
    always_comb begin
        is_unalloc = (tag == TAG_UNALLOC);
        is_live    = (tag[3:2] == TAG_LIVE_HI);
        kind       = is_live ? tag[1:0] : 2'b00;
    end
endmodule

// File: rtl/seg_bound_calc.sv
// Turns a table entry and an offset into a status and a physical address.
// Absent beats bounds. The address is forced to zero on any fault.
module seg_bound_calc
    import seg_xlate_pkg::*;
#(
    parameter int PA_W  = 36,
    parameter int OFF_W = 20
) (
    input  logic             present,
    input  logic [PA_W-1:0]  base,
    input  logic [OFF_W-1:0] length,
    input  logic [OFF_W-1:0] offset,
    output logic [2:0]       status,
    output logic [PA_W-1:0]  addr
);
    // presence first, then the length bound, then the sum
    always_comb begin
        status = ST_OK;
        addr   = '0;
        if (!present) begin
            status = ST_ABSENT;
        end else if (offset >= length) begin
            status = ST_BOUNDS;
        end else begin
            addr = base + PA_W'(offset);
        end
    end
endmodule

// File: rtl/seg_entry_cache.sv
// Small fully associative cache of segment table entries.
// Lookup is combinational. A fill writes the round-robin victim slot.
// An invalidate clears every valid slot whose index matches. When a fill
// and an invalidate hit the same slot in one cycle, the fill wins.
// Assumes a fill is only made for an index that is not already cached.
module seg_entry_cache #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 23,
    parameter int PA_W    = 36,
    parameter int LEN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_index,
    output logic             hit,
    output logic             hit_present,
    output logic [PA_W-1:0]  hit_base,
    output logic [LEN_W-1:0] hit_len,
    input  logic             fill,
    input  logic [IDX_W-1:0] fill_index,
    input  logic             fill_present,
    input  logic [PA_W-1:0]  fill_base,
    input  logic [LEN_W-1:0] fill_len,
    input  logic             inv_valid,
    input  logic [IDX_W-1:0] inv_index
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

    logic [PTR_W-1:0]   victim;
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] ent_pres;
    logic [PA_W-1:0]    ent_base [ENTRIES];
    logic [LEN_W-1:0]   ent_len  [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic             v_q;
        logic             p_q;
        logic [IDX_W-1:0] i_q;
        logic [PA_W-1:0]  b_q;
        logic [LEN_W-1:0] l_q;

        // slot update: fill into the victim, otherwise drop on invalidate
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (fill && victim == PTR_W'(g)) begin
                v_q <= 1'b1;
                p_q <= fill_present;
                i_q <= fill_index;
                b_q <= fill_base;
                l_q <= fill_len;
            end else if (inv_valid && v_q && i_q == inv_index) begin
                v_q <= 1'b0;
            end
        end

        assign match[g]    = v_q && (i_q == lk_index);
        assign ent_pres[g] = p_q;
        assign ent_base[g] = b_q;
        assign ent_len[g]  = l_q;
    end

    // select the matching slot's contents
    always_comb begin
        hit         = |match;
        hit_present = 1'b0;
        hit_base    = '0;
        hit_len     = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_present = ent_pres[i];
                hit_base    = ent_base[i];
                hit_len     = ent_len[i];
            end
        end
    end

    // round-robin victim pointer advances on each fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim <= '0;
        end else if (fill) begin
            victim <= (victim == PTR_LAST) ? '0 : victim + 1'b1;
        end
    end
endmodule

// File: rtl/seg_xlate.sv
// Segment table address translator top level.
// Accepts one lookup at a time. Sorts the tag, consults the entry cache,
// on a miss reads two table words and fills the cache, then re-checks.
// Assumes TABLE_BASE is a multiple of 8 words and that memory answers each
// one-cycle read request with exactly one mem_rvalid pulse.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int              IDX_W      = 23,
    parameter int              OFF_W      = 20,
    parameter int              PA_W       = 36,
    parameter int              WORD_W     = 48,
    parameter int              ENTRIES    = 8,
    parameter logic [PA_W-1:0] TABLE_BASE = 36'h0_4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_tag,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [OFF_W-1:0]  req_offset,
    output logic              resp_valid,
    output logic [2:0]        resp_status,
    output logic [1:0]        resp_kind,
    output logic [PA_W-1:0]   resp_addr,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              inv_valid,
    input  logic [IDX_W-1:0]  inv_index
);
    localparam int PRES_BIT = WORD_W - 1;
    localparam int ENT_SHIFT = 3;

    typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WAIT0, S_WAIT1} state_t;

    state_t            state;
    logic [3:0]        cur_tag;
    logic [IDX_W-1:0]  cur_index;
    logic [OFF_W-1:0]  cur_offset;
    logic              w0_present;
    logic [PA_W-1:0]   w0_base;
    logic              stale;

    logic              tag_unalloc, tag_live;
    logic [1:0]        tag_kind;
    logic              c_hit, c_present;
    logic [PA_W-1:0]   c_base;
    logic [OFF_W-1:0]  c_len;
    logic [2:0]        calc_status;
    logic [PA_W-1:0]   calc_addr;
    logic              inv_cur;
    logic              fill;
    logic [PA_W-1:0]   entry_addr;

    seg_tag_decode i_dec (
        .tag        (cur_tag),
        .is_unalloc (tag_unalloc),
        .is_live    (tag_live),
        .kind       (tag_kind)
    );

    seg_entry_cache #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .PA_W    (PA_W),
        .LEN_W   (OFF_W)
    ) i_cache (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_index     (cur_index),
        .hit          (c_hit),
        .hit_present  (c_present),
        .hit_base     (c_base),
        .hit_len      (c_len),
        .fill         (fill),
        .fill_index   (cur_index),
        .fill_present (w0_present),
        .fill_base    (w0_base),
        .fill_len     (mem_rdata[OFF_W-1:0]),
        .inv_valid    (inv_valid),
        .inv_index    (inv_index)
    );

    seg_bound_calc #(
        .PA_W  (PA_W),
        .OFF_W (OFF_W)
    ) i_calc (
        .present (c_present),
        .base    (c_base),
        .length  (c_len),
        .offset  (cur_offset),
        .status  (calc_status),
        .addr    (calc_addr)
    );

    // invalidate aimed at the index in flight, and the fill decision
    always_comb begin
        inv_cur    = inv_valid && (inv_index == cur_index);
        fill       = (state == S_WAIT1) && mem_rvalid && !stale && !inv_cur;
        entry_addr = TABLE_BASE + (PA_W'(cur_index) << ENT_SHIFT);
        req_ready  = (state == S_IDLE);
    end

    // remember whether the entry being fetched was invalidated meanwhile
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stale <= 1'b0;
        end else if (state == S_CHECK) begin
            stale <= inv_cur;
        end else if (inv_cur) begin
            stale <= 1'b1;
        end
    end

    // request sequencing, table reads and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            resp_valid  <= 1'b0;
            resp_status <= ST_OK;
            resp_kind   <= 2'b00;
            resp_addr   <= '0;
            mem_req     <= 1'b0;
            mem_addr    <= '0;
            cur_tag     <= '0;
            cur_index   <= '0;
            cur_offset  <= '0;
            w0_present  <= 1'b0;
            w0_base     <= '0;
        end else begin
            resp_valid <= 1'b0;
            mem_req    <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        cur_tag    <= req_tag;
                        cur_index  <= req_index;
                        cur_offset <= req_offset;
                        state      <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (tag_unalloc || !tag_live) begin
                        resp_valid  <= 1'b1;
                        resp_status <= tag_unalloc ? ST_UNALLOC : ST_BADTAG;
                        resp_kind   <= 2'b00;
                        resp_addr   <= '0;
                        state       <= S_IDLE;
                    end else if (c_hit) begin
                        resp_valid  <= 1'b1;
                        resp_status <= calc_status;
                        resp_kind   <= tag_kind;
                        resp_addr   <= calc_addr;
                        state       <= S_IDLE;
                    end else begin
                        mem_req  <= 1'b1;
                        mem_addr <= entry_addr;
                        state    <= S_WAIT0;
                    end
                end
                S_WAIT0: begin
                    if (mem_rvalid) begin
                        w0_present <= mem_rdata[PRES_BIT];
                        w0_base    <= mem_rdata[PA_W-1:0];
                        mem_req    <= 1'b1;
                        mem_addr   <= entry_addr + PA_W'(1);
                        state      <= S_WAIT1;
                    end
                end
                S_WAIT1: begin
                    if (mem_rvalid) begin
                        state <= S_CHECK;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seg_xlate_checker.sv
// Port-level properties of the segment translator, bound to every instance.
module seg_xlate_checker #(
    parameter int PA_W = 36
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            resp_valid,
    input logic [2:0]      resp_status,
    input logic [PA_W-1:0] resp_addr,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr
);
    // table reads are single-cycle pulses
    assert_mem_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // reads only touch words 0 and 1 of an eight-word entry
    assert_mem_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:1] == 2'b00));

    // fault results carry a zero address
    assert_fault_addr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status != 3'd0) |-> (resp_addr == '0));

    // only defined status codes appear
    assert_status_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_status <= 3'd4));

    // tag-class faults are answered without touching memory
    assert_tag_fault_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_status == 3'd1 || resp_status == 3'd4))
            |-> (!$past(mem_req) && !$past(mem_req, 2)));

    // an accepted request makes the block busy next cycle
    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // a result is presented as the block returns to idle
    assert_idle_with_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);
endmodule

bind seg_xlate seg_xlate_checker #(.PA_W(PA_W)) i_seg_xlate_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_status (resp_status),
    .resp_addr   (resp_addr),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
    localparam logic [35:0] TB_BASE = 36'h0_4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_tag = '0;
    logic [22:0] req_index = '0;
    logic [19:0] req_offset = '0;
    logic        resp_valid;
    logic [2:0]  resp_status;
    logic [1:0]  resp_kind;
    logic [35:0] resp_addr;
    logic        mem_req;
    logic [35:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [47:0] mem_rdata = '0;
    logic        inv_valid = 1'b0;
    logic [22:0] inv_index = '0;

    int checks = 0;
    int bad = 0;
    int reads = 0;
    int cycles = 0;
    int gen = 0;

    always #2ns clk = ~clk;

    seg_xlate #(.TABLE_BASE(TB_BASE)) i_seg_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_tag(req_tag), .req_index(req_index), .req_offset(req_offset),
        .resp_valid(resp_valid), .resp_status(resp_status),
        .resp_kind(resp_kind), .resp_addr(resp_addr),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .inv_valid(inv_valid), .inv_index(inv_index)
    );

    // table model
    function automatic logic tb_present(input logic [22:0] idx);
        return (idx % 23'd5) != 23'd3;
    endfunction
    function automatic logic [35:0] tb_base(input logic [22:0] idx, input int g);
        return (36'(idx) << 11) + (36'(g) << 30);
    endfunction
    function automatic logic [19:0] tb_len(input logic [22:0] idx, input int g);
        return 20'(idx * 7 + 23'(g * 3) + 23'd5);
    endfunction
    function automatic logic [47:0] tb_word(input logic [35:0] a, input int g);
        logic [35:0] rel;
        logic [22:0] idx;
        rel = a - TB_BASE;
        idx = rel[25:3];
        if (rel[2:0] == 3'd0) return {tb_present(idx), 11'd0, tb_base(idx, g)};
        if (rel[2:0] == 3'd1) return {28'd0, tb_len(idx, g)};
        return 48'hDEAD_0000_0000;
    endfunction
    function automatic logic [2:0] exp_status(input logic [3:0] t, input logic [22:0] idx,
                                              input logic [19:0] off, input int g);
        if (t == 4'h5) return 3'd1;
        if (t[3:2] != 2'b11) return 3'd4;
        if (!tb_present(idx)) return 3'd2;
        if (off >= tb_len(idx, g)) return 3'd3;
        return 3'd0;
    endfunction
    function automatic logic [35:0] exp_addr(input logic [3:0] t, input logic [22:0] idx,
                                             input logic [19:0] off, input int g);
        if (exp_status(t, idx, off, g) != 3'd0) return 36'd0;
        return tb_base(idx, g) + 36'(off);
    endfunction

    // memory with two-cycle read latency
    logic        p1 = 1'b0, p2 = 1'b0;
    logic [35:0] a1 = '0, a2 = '0;
    always @(posedge clk) begin
        p1 <= mem_req;
        a1 <= mem_addr;
        p2 <= p1;
        a2 <= a1;
        mem_rvalid <= p2;
        mem_rdata  <= tb_word(a2, gen);
        if (mem_req) reads <= reads + 1;
        cycles <= cycles + 1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    // watchdog
    initial begin
        wait (cycles > 150000);
        checks++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_run();
    end

    // one lookup; optional invalidate of the same index one cycle after acceptance
    task automatic lookup(input logic [3:0] t, input logic [22:0] idx, input logic [19:0] off,
                          input bit inv_mid, output logic [2:0] st, output logic [35:0] ad,
                          output logic [1:0] kd, output int lat, output int nr);
        int r0;
        @(negedge clk);
        r0 = reads;
        req_valid = 1'b1; req_tag = t; req_index = idx; req_offset = off;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (inv_mid) begin inv_valid = 1'b1; inv_index = idx; end
        lat = 0;
        while (1) begin
            @(posedge clk);
            @(negedge clk);
            inv_valid = 1'b0;
            lat++;
            if (resp_valid) break;
            if (lat > 60) begin
                checks++; bad++;
                $display("FAIL lookup timeout actual=%0d expected=%0d", lat, 60);
                break;
            end
        end
        st = resp_status; ad = resp_addr; kd = resp_kind;
        @(posedge clk);
        @(negedge clk);
        nr = reads - r0;
    endtask

    task automatic invalidate(input logic [22:0] idx);
        @(negedge clk);
        inv_valid = 1'b1; inv_index = idx;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [2:0]  st;
        logic [35:0] ad;
        logic [1:0]  kd;
        int lat, nr;
        void'($urandom(32'h5EED));
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 64'(req_ready), 64'd1);
        check("R1 resp_valid", 64'(resp_valid), 64'd0);
        check("R1 mem_req", 64'(mem_req), 64'd0);

        // R2 tag classes
        lookup(4'h5, 23'd1000, 20'd1, 0, st, ad, kd, lat, nr);
        check("R2 unalloc status", 64'(st), 64'd1);
        check("R2 unalloc reads", 64'(nr), 64'd0);
        lookup(4'h3, 23'd1000, 20'd1, 0, st, ad, kd, lat, nr);
        check("R2 badtag status", 64'(st), 64'd4);
        check("R2 badtag reads", 64'(nr), 64'd0);

        // R1 first access misses, R3 two reads, R4 address
        lookup(4'hE, 23'd1001, 20'd10, 0, st, ad, kd, lat, nr);
        check("R1 first lookup reads", 64'(nr), 64'd2);
        check("R4 ok status", 64'(st), 64'd0);
        check("R4 address", 64'(ad), 64'(exp_addr(4'hE, 23'd1001, 20'd10, gen)));
        check("R2 kind", 64'(kd), 64'd2);
        // R7 hit
        lookup(4'hD, 23'd1001, 20'd20, 0, st, ad, kd, lat, nr);
        check("R7 hit reads", 64'(nr), 64'd0);
        check("R7 hit latency", 64'(lat), 64'd1);
        check("R4 hit address", 64'(ad), 64'(exp_addr(4'hD, 23'd1001, 20'd20, gen)));
        // R6 bound edge
        lookup(4'hC, 23'd1001, tb_len(23'd1001, gen) - 20'd1, 0, st, ad, kd, lat, nr);
        check("R6 last word ok", 64'(st), 64'd0);
        lookup(4'hC, 23'd1001, tb_len(23'd1001, gen), 0, st, ad, kd, lat, nr);
        check("R6 bounds status", 64'(st), 64'd3);
        check("R6 bounds addr zero", 64'(ad), 64'd0);
        // R5 absent beats bounds
        lookup(4'hF, 23'd1003, 20'hFFFFF, 0, st, ad, kd, lat, nr);
        check("R5 absent status", 64'(st), 64'd2);
        check("R5 absent addr zero", 64'(ad), 64'd0);

        // R8 round robin: fresh cache, nine distinct fills
        do_reset();
        for (int i = 0; i < 9; i++) begin
            lookup(4'hC, 23'(100 + i), 20'd0, 0, st, ad, kd, lat, nr);
        end
        lookup(4'hC, 23'd100, 20'd0, 0, st, ad, kd, lat, nr);
        check("R8 oldest evicted", 64'(nr), 64'd2);
        lookup(4'hC, 23'd102, 20'd0, 0, st, ad, kd, lat, nr);
        check("R8 newer kept", 64'(nr), 64'd0);
        lookup(4'hC, 23'd108, 20'd0, 0, st, ad, kd, lat, nr);
        check("R8 last fill kept", 64'(nr), 64'd0);

        // R9 invalidate while idle picks up new table contents
        gen = 1;
        invalidate(23'd102);
        lookup(4'hC, 23'd102, 20'd3, 0, st, ad, kd, lat, nr);
        check("R9 refetch reads", 64'(nr), 64'd2);
        check("R9 new address", 64'(ad), 64'(exp_addr(4'hC, 23'd102, 20'd3, gen)));

        // R10 invalidate during the fetch
        lookup(4'hC, 23'd200, 20'd4, 1, st, ad, kd, lat, nr);
        check("R10 fetch repeated", 64'(nr), 64'd4);
        check("R10 address", 64'(ad), 64'(exp_addr(4'hC, 23'd200, 20'd4, gen)));

        // random phase on a fresh cache
        do_reset();
        for (int n = 0; n < 200; n++) begin
            int r;
            logic [3:0]  t;
            logic [22:0] idx;
            logic [19:0] off;
            r = int'($urandom % 10);
            t = (r == 0) ? 4'h5 : (r == 1) ? 4'(($urandom % 11) < 5 ? ($urandom % 5) : 6 + ($urandom % 6)) : 4'(12 + r % 4);
            idx = 23'(1000 + ($urandom % 12));
            off = 20'($urandom & 32'h3FFF);
            lookup(t, idx, off, 0, st, ad, kd, lat, nr);
            check("R4 R5 R6 random status", 64'(st), 64'(exp_status(t, idx, off, gen)));
            check("R4 random address", 64'(ad), 64'(exp_addr(t, idx, off, gen)));
        end
        finish_run();
    end
endmodule